// File: doc/BRIEF.md
# Configuration Boot Loader over a Two-Wire Serial Bus

This block masters a two-wire serial bus and reads one external serial EEPROM. It copies the EEPROM's contents into on-chip configuration registers with no host involvement. The load starts by itself once reset is released. It can be started again at any later time with a one-cycle request pulse. The EEPROM stream is a series of (register address, data) byte pairs. Each pair becomes one write strobe on a plain register-write port. The same address and data are also kept in two status outputs for test observation.

Before its first transfer, the loader checks the level of the clock line. A board that ties the clock line to ground has no EEPROM fitted, and the loader then stays silent until the next reset. Both bus lines are open-drain: the block either pulls a line low or releases it. A one-cycle interrupt marks the end of every load attempt. An error flag tells a clean finish apart from a missing acknowledge.

Top module: `cfg_boot_loader`

## Requirements
- R1: After reset is released, with the clock line high, the loader starts a load by itself: `busy_o` is high within 10 cycles and no `reload_i` is needed.
- R2: A `reload_i` pulse while the loader is idle runs the whole load again. Without such a pulse, no further transfer or register write occurs after a load ends.
- R3: If the clock line reads low when it is sampled after reset, the loader never drives either line, keeps `busy_o` low, raises no interrupt and ignores `reload_i` until the next reset.
- R4: The clock line has a period of at least CLK_PER_SCL system cycles (default 120), and exactly that period between consecutive bits of one byte.
- R5: Each load sends a start, then byte 0xA0, then byte 0x00, then a repeated start, then byte 0xA1, and then reads bytes. Every byte is 8 bits, most significant bit first, followed by a ninth acknowledge bit.
- R6: Read bytes are taken as pairs in the order address then data. Each pair gives exactly one one-cycle `reg_we_o` pulse carrying that address and data. An address byte of 0xFF ends the load: the master answers it with a not-acknowledge and then sends a stop. A stream that begins with 0xFF gives no writes.
- R7: `stat_addr_o`/`stat_data_o` take the address and data of each register write in the cycle of its strobe, and change at no other time.
- R8: The end of a load is marked by a one-cycle `irq_o` pulse after the stop condition, with `busy_o` low. `err_o` stays low when every acknowledge was received.
- R9: A missing acknowledge on any byte the master sends ends the load with a stop. It sets `err_o`, still pulses `irq_o` and gives no register write. `err_o` clears when the next load starts.
- R10: The data line changes while the clock line is released only during a start or stop condition. Once a load has ended, both lines are released.
- R11: During reset, all outputs are low: both lines are released, there is no strobe, no interrupt and no error, and the status outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reload_i | input | 1 | One-cycle request to run the load again |
| scl_i | input | 1 | Level of the clock line |
| sda_i | input | 1 | Level of the data line |
| scl_oe_o | output | 1 | 1 pulls the clock line low |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| reg_we_o | output | 1 | Register write strobe |
| reg_addr_o | output | 8 | Register write address |
| reg_data_o | output | 8 | Register write data |
| stat_addr_o | output | 8 | Status copy of the last written address |
| stat_data_o | output | 8 | Status copy of the last written data |
| busy_o | output | 1 | Load in progress |
| err_o | output | 1 | Last load ended on a missing acknowledge |
| irq_o | output | 1 | One-cycle pulse at the end of a load |

## Verification
The assertions check the following on every cycle:
- the data line stays quiet while the clock line is released, except during start and stop conditions;
- the write strobe and the interrupt are single pulses;
- the status outputs move only with a write strobe;
- an absent EEPROM leaves the bus untouched;
- an error never comes with a write.

Only the bench's scenarios can show the rest. It uses an EEPROM model that answers on the bus, and it shows the exact byte sequence on the wires and the records that reach the register port. It also shows the measured clock period, the not-acknowledge on the end marker, error recovery on the next reload, and that a grounded clock line keeps the block quiet even when a reload is requested.

// File: rtl/cbl_pkg.sv
package cbl_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {CMD_START, CMD_STOP, CMD_WR, CMD_RD} cmd_e;

  typedef enum logic [3:0] {
    S_PROBE, S_ABSENT, S_IDLE, S_START1, S_DEVW, S_WADDR,
    S_START2, S_DEVR, S_RADDR, S_RDATA, S_STOP
  } seq_e;
endpackage

// File: rtl/cbl_sync.sv
module cbl_sync #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= {2{RST_VAL}};
    else         ff_q <= {ff_q[0], d_i};
  end

  assign q_o = ff_q[1];
endmodule

// File: rtl/cbl_tick_gen.sv
module cbl_tick_gen #(
  parameter int unsigned QUARTER = 30
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = (QUARTER > 1) ? $clog2(QUARTER) : 1;
  localparam logic [CW-1:0] LAST = CW'(QUARTER - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || tick_o)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/cbl_bit_engine.sv
module cbl_bit_engine
  import cbl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              cmd_valid_i,
  input  cmd_e              cmd_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  input  logic              rd_nack_i,
  input  logic              sda_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              ack_ok_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              scl_rel_o,
  output logic              sda_rel_o,
  output logic              cond_o
);
  logic [1:0]        ph_q;
  logic [3:0]        bit_q;
  logic [BYTE_W-1:0] sh_q;
  cmd_e              cmd_q;
  logic              scl_q, sda_q, ack_q, busy_q, done_q;

  logic last_bit, is_wr, is_bit;
  assign last_bit = (bit_q == 4'd8);
  assign is_wr    = (cmd_q == CMD_WR);
  assign is_bit   = (cmd_q == CMD_WR) || (cmd_q == CMD_RD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= '0; bit_q <= '0; sh_q <= '0; cmd_q <= CMD_START;
      scl_q <= 1'b1; sda_q <= 1'b1; ack_q <= 1'b0;
      busy_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (cmd_valid_i) begin
          busy_q <= 1'b1; cmd_q <= cmd_i; sh_q <= tx_byte_i;
          bit_q <= '0; ph_q <= '0;
        end
      end else if (tick_i) begin
        ph_q <= ph_q + 2'd1;
        case (ph_q)
          2'd0: begin  // clock is low here: set up data
            if (cmd_q == CMD_START) sda_q <= 1'b1;
            else if (cmd_q == CMD_STOP) begin scl_q <= 1'b0; sda_q <= 1'b0; end
            else begin
              scl_q <= 1'b0;
              if (!last_bit) sda_q <= is_wr ? sh_q[BYTE_W-1] : 1'b1;
              else           sda_q <= is_wr ? 1'b1 : rd_nack_i;
            end
          end
          2'd1: scl_q <= 1'b1;
          2'd2: begin
            if (cmd_q == CMD_START)     sda_q <= 1'b0;
            else if (cmd_q == CMD_STOP) sda_q <= 1'b1;
            else if (!last_bit)         sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
            else                        ack_q <= !sda_i;
          end
          default: begin
            if (cmd_q != CMD_STOP) scl_q <= 1'b0;
            if (!is_bit || last_bit) begin busy_q <= 1'b0; done_q <= 1'b1; end
            else bit_q <= bit_q + 4'd1;
          end
        endcase
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign ack_ok_o  = ack_q;
  assign rx_byte_o = sh_q;
  assign scl_rel_o = scl_q;
  assign sda_rel_o = sda_q;
  assign cond_o    = busy_q && !is_bit;
endmodule

// File: rtl/cfg_boot_loader.sv
module cfg_boot_loader
  import cbl_pkg::*;
#(
  parameter int unsigned      CLK_PER_SCL = 120,
  parameter logic [6:0]       DEV_ADDR    = 7'h50,
  parameter logic [BYTE_W-1:0] WORD_ADDR  = 8'h00,
  parameter logic [BYTE_W-1:0] END_ADDR   = 8'hFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reload_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  output logic              reg_we_o,
  output logic [BYTE_W-1:0] reg_addr_o,
  output logic [BYTE_W-1:0] reg_data_o,
  output logic [BYTE_W-1:0] stat_addr_o,
  output logic [BYTE_W-1:0] stat_data_o,
  output logic              busy_o,
  output logic              err_o,
  output logic              irq_o
);
  localparam int unsigned QUARTER = CLK_PER_SCL / 4;

  seq_e              state_q;
  logic              wait_q, err_q, irq_q, we_q;
  logic [1:0]        probe_q;
  logic [BYTE_W-1:0] addr_q, wa_q, wd_q, sta_q, std_q;

  logic scl_s, sda_s, tick, eng_busy, eng_done, eng_ack, eng_cond;
  logic scl_rel, sda_rel, cmd_valid, rd_nack, is_op, absent_w;
  logic [BYTE_W-1:0] rx, tx;
  cmd_e cmd;

  cbl_sync #(.RST_VAL(1'b1)) u_sync_scl (.clk_i, .rst_ni, .d_i(scl_i), .q_o(scl_s));
  cbl_sync #(.RST_VAL(1'b1)) u_sync_sda (.clk_i, .rst_ni, .d_i(sda_i), .q_o(sda_s));

  cbl_tick_gen #(.QUARTER(QUARTER)) u_tick (
    .clk_i, .rst_ni, .en_i(eng_busy), .tick_o(tick)
  );

  cbl_bit_engine u_eng (
    .clk_i, .rst_ni, .tick_i(tick), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .tx_byte_i(tx), .rd_nack_i(rd_nack), .sda_i(sda_s),
    .busy_o(eng_busy), .done_o(eng_done), .ack_ok_o(eng_ack), .rx_byte_o(rx),
    .scl_rel_o(scl_rel), .sda_rel_o(sda_rel), .cond_o(eng_cond)
  );

  always_comb begin
    cmd = CMD_START; tx = '0; is_op = 1'b1;
    case (state_q)
      S_START1, S_START2: cmd = CMD_START;
      S_DEVW:             begin cmd = CMD_WR; tx = {DEV_ADDR, 1'b0}; end
      S_WADDR:            begin cmd = CMD_WR; tx = WORD_ADDR; end
      S_DEVR:             begin cmd = CMD_WR; tx = {DEV_ADDR, 1'b1}; end
      S_RADDR, S_RDATA:   cmd = CMD_RD;
      S_STOP:             cmd = CMD_STOP;
      default:            is_op = 1'b0;
    endcase
  end

  assign cmd_valid = is_op && !eng_busy && !wait_q;
  assign rd_nack   = (state_q == S_RADDR) && (rx == END_ADDR);
  assign absent_w  = (state_q == S_ABSENT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_PROBE; wait_q <= 1'b0; err_q <= 1'b0; irq_q <= 1'b0;
      we_q <= 1'b0; probe_q <= '0; addr_q <= '0;
      wa_q <= '0; wd_q <= '0; sta_q <= '0; std_q <= '0;
    end else begin
      we_q  <= 1'b0;
      irq_q <= 1'b0;
      if (cmd_valid) wait_q <= 1'b1;
      case (state_q)
        S_PROBE: begin
          probe_q <= probe_q + 2'd1;
          if (probe_q == 2'd3) state_q <= scl_s ? S_START1 : S_ABSENT;
        end
        S_ABSENT: ;
        S_IDLE: if (reload_i) begin state_q <= S_START1; err_q <= 1'b0; end
        default: if (eng_done) begin
          wait_q <= 1'b0;
          case (state_q)
            S_START1: state_q <= S_DEVW;
            S_START2: state_q <= S_DEVR;
            S_DEVW, S_WADDR, S_DEVR: begin
              if (!eng_ack) begin state_q <= S_STOP; err_q <= 1'b1; end
              else if (state_q == S_DEVW)  state_q <= S_WADDR;
              else if (state_q == S_WADDR) state_q <= S_START2;
              else                         state_q <= S_RADDR;
            end
            S_RADDR: begin
              if (rx == END_ADDR) state_q <= S_STOP;
              else begin addr_q <= rx; state_q <= S_RDATA; end
            end
            S_RDATA: begin
              we_q <= 1'b1; wa_q <= addr_q; wd_q <= rx;
              sta_q <= addr_q; std_q <= rx;
              state_q <= S_RADDR;
            end
            default: begin state_q <= S_IDLE; irq_q <= 1'b1; end
          endcase
        end
      endcase
    end
  end

  assign scl_oe_o    = !scl_rel;
  assign sda_oe_o    = !sda_rel;
  assign reg_we_o    = we_q;
  assign reg_addr_o  = wa_q;
  assign reg_data_o  = wd_q;
  assign stat_addr_o = sta_q;
  assign stat_data_o = std_q;
  assign busy_o      = is_op;
  assign err_o       = err_q;
  assign irq_o       = irq_q;
endmodule

// File: rtl/cbl_checker.sv
module cbl_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_oe_i,
  input logic       sda_oe_i,
  input logic       reg_we_i,
  input logic [7:0] stat_addr_i,
  input logic [7:0] stat_data_i,
  input logic       busy_i,
  input logic       err_i,
  input logic       irq_i,
  input logic       cond_i,
  input logic       absent_i
);
  AST_SDA_QUIET_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scl_oe_i && !$past(scl_oe_i) && (sda_oe_i != $past(sda_oe_i))) |-> cond_i); // R10
  AST_WE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |=> !reg_we_i); // R6
  AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |=> !irq_i); // R8
  AST_IRQ_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (!busy_i && !scl_oe_i && !sda_oe_i)); // R8
  AST_STAT_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_addr_i != $past(stat_addr_i)) || (stat_data_i != $past(stat_data_i))) |-> reg_we_i); // R7
  AST_ABSENT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    absent_i |-> (!scl_oe_i && !sda_oe_i && !busy_i && !irq_i)); // R3
  AST_ERR_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |-> !reg_we_i); // R9
endmodule

bind cfg_boot_loader cbl_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_oe_i(scl_oe_o), .sda_oe_i(sda_oe_o),
  .reg_we_i(reg_we_o), .stat_addr_i(stat_addr_o), .stat_data_i(stat_data_o),
  .busy_i(busy_o), .err_i(err_o), .irq_i(irq_o), .cond_i(eng_cond),
  .absent_i(absent_w)
);

// File: tb/cfg_boot_loader_test.sv
module cfg_boot_loader_test;
  localparam int PER = 120;
  localparam int NREC = 4;
  localparam logic [15:0] REC_TAB [NREC] = '{16'h1022, 16'h11A5, 16'h3C00, 16'h7F81};

  logic clk = 1'b0, rst_n = 1'b0, reload = 1'b0;
  logic scl_gnd = 1'b0, slave_low = 1'b0, nack_dev = 1'b0;
  logic scl_oe, sda_oe, we, busy, err, irq;
  logic [7:0] waddr, wdata, saddr, sdata;
  wire scl_line = !(scl_oe || scl_gnd);
  wire sda_line = !(sda_oe || slave_low);

  always #4 clk = ~clk;

  cfg_boot_loader uut (
    .clk_i(clk), .rst_ni(rst_n), .reload_i(reload), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .reg_we_o(we), .reg_addr_o(waddr),
    .reg_data_o(wdata), .stat_addr_o(saddr), .stat_data_o(sdata),
    .busy_o(busy), .err_o(err), .irq_o(irq)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // EEPROM model
  logic [7:0] mem [16];
  logic [7:0] rx_log [8];
  int rx_n = 0, mnack_n = 0, ptr = 0, mode = 0, bcnt = 0;
  logic [7:0] sh = 0, txb = 0;
  bit ackph = 0, first = 0, ackdone = 0, mnack = 0, pscl = 1, psda = 1;

  always @(negedge clk) begin
    bit s_scl, s_sda;
    s_scl = scl_line; s_sda = sda_line;
    if (s_scl && pscl && psda && !s_sda) begin
      mode = 1; bcnt = 0; ackph = 0; first = 1; slave_low = 0;
    end else if (s_scl && pscl && !psda && s_sda) begin
      mode = 0; slave_low = 0;
    end else if (s_scl && !pscl) begin
      if (mode == 1 && bcnt < 8) begin sh = {sh[6:0], s_sda}; bcnt++; end
      else if (mode == 2) begin
        if (bcnt < 8) bcnt++;
        else begin ackdone = 1; mnack = s_sda; end
      end
    end else if (!s_scl && pscl) begin
      if (mode == 1) begin
        if (bcnt == 8 && !ackph) begin
          if (rx_n < 8) begin rx_log[rx_n] = sh; rx_n++; end
          ackph = 1;
          if (first && (sh[7:1] != 7'h50 || nack_dev)) mode = 0;
          else slave_low = 1;
        end else if (ackph) begin
          slave_low = 0; ackph = 0; bcnt = 0;
          if (first) begin
            first = 0;
            if (sh[0]) begin
              mode = 2; txb = mem[ptr[3:0]]; ptr++; ackdone = 0; slave_low = !txb[7];
            end
          end else ptr = int'(sh);
        end
      end else if (mode == 2) begin
        if (ackdone) begin
          ackdone = 0;
          if (mnack) begin mnack_n++; mode = 0; slave_low = 0; end
          else begin txb = mem[ptr[3:0]]; ptr++; bcnt = 0; slave_low = !txb[7]; end
        end else if (bcnt < 8) slave_low = !txb[7-bcnt];
        else slave_low = 0;
      end
    end
    pscl = s_scl; psda = s_sda;
  end

  // monitors
  logic [7:0] cap_a [16];
  logic [7:0] cap_d [16];
  int cap_n = 0, irq_n = 0, min_per = 1000000, last_rise = -1;
  bit mscl = 1;
  always @(negedge clk) begin
    cyc++;
    if (we && cap_n < 16) begin cap_a[cap_n] = waddr; cap_d[cap_n] = wdata; cap_n++; end
    if (irq) irq_n++;
    if (scl_line && !mscl) begin
      if (last_rise >= 0 && cyc - last_rise < min_per) min_per = cyc - last_rise;
      last_rise = cyc;
    end
    mscl = scl_line;
    if (cyc > 190000 && !done_flag) begin
      done_flag = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic wait_irq();
    int n0 = irq_n;
    while (irq_n == n0) @(negedge clk);
  endtask

  task automatic pulse_reload();
    @(negedge clk); reload = 1'b1;
    @(negedge clk); reload = 1'b0;
  endtask

  task automatic load_tab(input int n, input logic [7:0] amod, input logic [7:0] dmod);
    for (int i = 0; i < 16; i++) mem[i] = 8'hFF;
    for (int i = 0; i < n; i++) begin
      mem[2*i]   = REC_TAB[i][15:8] + amod;
      mem[2*i+1] = REC_TAB[i][7:0] ^ dmod;
    end
  endtask

  initial begin
    int n0;
    load_tab(NREC, 8'h00, 8'h00);
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!scl_oe && !sda_oe && !we && !irq && !err && !busy, "R11 outputs in reset",
        {scl_oe, sda_oe, we, irq, err, busy}, 0);
    chk(saddr == 0 && sdata == 0, "R11 status zero", {saddr, sdata}, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(busy, "R1 auto start", busy, 1);
    wait_irq();
    chk(cap_n == NREC, "R6 record count", cap_n, NREC);
    for (int i = 0; i < NREC; i++)
      chk({cap_a[i], cap_d[i]} == REC_TAB[i], "R6 record", {cap_a[i], cap_d[i]}, REC_TAB[i]);
    chk(rx_log[0] == 8'hA0 && rx_log[1] == 8'h00 && rx_log[2] == 8'hA1 && rx_n == 3,
        "R5 frame bytes", {rx_log[0], rx_log[1], rx_log[2]}, 24'hA000A1);
    chk(mnack_n == 1, "R6 end marker nack", mnack_n, 1);
    chk(min_per == PER, "R4 clock period", min_per, PER);
    chk(!err && !busy, "R8 clean end", {err, busy}, 0);
    chk({saddr, sdata} == REC_TAB[NREC-1], "R7 status mirror", {saddr, sdata}, REC_TAB[NREC-1]);
    chk(!scl_oe && !sda_oe, "R10 lines released", {scl_oe, sda_oe}, 0);
    n0 = cap_n;
    repeat (1000) @(negedge clk);
    chk(cap_n == n0 && irq_n == 1 && !busy, "R2 no self restart", cap_n, n0);
    chk({saddr, sdata} == REC_TAB[NREC-1], "R7 status held", {saddr, sdata}, REC_TAB[NREC-1]);

    // R2 reload with new contents
    load_tab(2, 8'h01, 8'h5A);
    cap_n = 0; ptr = 0;
    pulse_reload();
    wait_irq();
    chk(cap_n == 2, "R2 reload count", cap_n, 2);
    for (int i = 0; i < 2; i++)
      chk(cap_a[i] == REC_TAB[i][15:8] + 8'h01 && cap_d[i] == (REC_TAB[i][7:0] ^ 8'h5A),
          "R2 reload record", {cap_a[i], cap_d[i]},
          {REC_TAB[i][15:8] + 8'h01, REC_TAB[i][7:0] ^ 8'h5A});

    // R6 empty stream
    load_tab(0, 8'h00, 8'h00);
    cap_n = 0;
    pulse_reload();
    wait_irq();
    chk(cap_n == 0 && !err, "R6 empty stream", cap_n, 0);

    // R9 missing acknowledge
    nack_dev = 1'b1;
    load_tab(NREC, 8'h00, 8'h00);
    cap_n = 0;
    pulse_reload();
    wait_irq();
    chk(err, "R9 error flag", err, 1);
    chk(cap_n == 0, "R9 no writes", cap_n, 0);
    chk(!scl_oe && !sda_oe && !busy, "R9 stop and idle", {scl_oe, sda_oe, busy}, 0);
    nack_dev = 1'b0;
    pulse_reload();
    @(negedge clk);
    chk(!err && busy, "R9 error cleared on restart", {err, busy}, 1);
    wait_irq();
    chk(cap_n == NREC && !err, "R9 recovery load", cap_n, NREC);

    // R3 absent device
    rst_n = 1'b0; scl_gnd = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    n0 = irq_n; cap_n = 0;
    repeat (2000) @(negedge clk);
    chk(!busy && !scl_oe && !sda_oe, "R3 absent quiet", {busy, scl_oe, sda_oe}, 0);
    pulse_reload();
    scl_gnd = 1'b0;
    repeat (2000) @(negedge clk);
    chk(!busy && irq_n == n0 && cap_n == 0 && !sda_oe, "R3 reload ignored",
        {busy, cap_n[3:0]}, 0);

    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule